// File: doc/BRIEF.md
# Deserializer Frame Lock Detector

This block sits behind a bit-aligned receive path and turns a one-bit-per-clock stream into 10-bit words. Each frame on the line is 12 bits long: an opening marker bit that must be 1, ten payload bits, and a closing marker bit that must be 0. The two marker bits carry the embedded clock. The block checks them on every frame to decide whether it is still framed correctly.

Out of reset the block is unlocked and hunts bit by bit for a sync frame, which is six ones followed by six zeros. Once it finds one, it is locked and cuts the stream into frames from the next bit on. Each completed frame is delivered as a word with a one-cycle valid strobe. A short run of bad marker bits is tolerated. Lock is given up only when four frames in a row are bad. The three words delivered during that run may be corrupt. When lock is won back, the block pulses a request that the sender repeat those words. The lock output has inverted sense: it is high while unlocked.

Top module: `lkd_deser_lock`

## Requirements
- R1: While reset is applied, lock_n is 1, data_valid is 0, resend_req is 0 and data_out is 0.
- R2: While unlocked, the block tests every bit position. When the latest 12 received bits, oldest first, are 111111000000, lock_n goes low on the clock edge that samples the final 0.
- R3: Once locked, frames are consecutive 12-bit groups. The first group starts with the bit after the sync pattern. A frame is valid when its first bit is 1 and its last bit is 0.
- R4: Words are delivered on the edge that samples a frame's last bit. On that edge data_out loads the ten middle bits, with the first payload bit received in data_out[0] and the last in data_out[9]. data_valid is high for exactly the one cycle after that edge.
- R5: An invalid frame that is the first, second or third in a row still delivers its word and keeps lock_n low.
- R6: A valid frame clears the run of invalid frames, so three invalid, one valid, then three invalid frames keeps the block locked.
- R7: On the fourth consecutive invalid frame, lock_n rises on the edge that samples its last bit, and no word is delivered for it.
- R8: data_valid is never high while lock_n is high, and bits received while unlocked produce no word.
- R9: When lock is regained after a loss, resend_req is high for one cycle, in the same cycle that lock_n first reads low. The first lock after reset gives no pulse.
- R10: After a loss, the sync search uses only bits received after the loss was declared, so a sync pattern that straddles the loss edge does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Received serial bit, one per clock |
| lock_n | output | 1 | High while unlocked, low while locked |
| data_out | output | 10 | Last delivered payload word |
| data_valid | output | 1 | One-cycle strobe for a new word on data_out |
| resend_req | output | 1 | One-cycle request to repeat the three words before a loss |

## Verification
Word delivery and loss declaration fall on the same clock edge: the edge that samples the last bit of the fourth bad frame in a row. There, loss must win, so lock_n rises and no strobe appears. The bench provokes this edge directly with runs of exactly three and exactly four bad frames, and again at random from a mix of good and corrupted frames. It judges each bit time against a bench model of the framing rules. A second directed case ends the fourth bad frame with six ones and follows it with six zeros, to show that the hunt ignores the history from before the loss.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
   // Sync pattern of a frame of width w: upper half ones, lower half zeros (oldest bit is MSB)
   function automatic logic [31:0] sync_word(input int w);
      logic [31:0] p;
      p = '0;
      for (int i = 0; i < w; i++) begin
         if (i >= w / 2) p[i] = 1'b1;
      end
      return p;
   endfunction
endpackage

// File: rtl/lkd_shifter.sv
module lkd_shifter #(
   parameter int DATA_W    = 10,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              bit_in,
   output logic              sync_hit,
   output logic              frame_ok,
   output logic [DATA_W-1:0] word
);
   import lkd_pkg::*;
   localparam int FRAME_W = DATA_W + 2;
   localparam logic [31:0] SYNC32 = sync_word(FRAME_W);
   localparam logic [FRAME_W-1:0] SYNC_PAT = SYNC32[FRAME_W-1:0];

   logic [FRAME_W-2:0] hist;
   logic [FRAME_W-1:0] win;

   assign win = {hist, bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hist <= '0;
      else if (clr) hist <= '0;
      else          hist <= win[FRAME_W-2:0];
   end

   assign sync_hit = (win == SYNC_PAT);
   assign frame_ok = win[FRAME_W-1] & ~win[0];

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (LSB_FIRST) begin : g_lsb
         assign word[i] = win[DATA_W-i];
      end else begin : g_msb
         assign word[i] = win[i+1];
      end
   end
endmodule

// File: rtl/lkd_miss_counter.sv
module lkd_miss_counter #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic bad,
   output logic limit_hit
);
   localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] run;

   assign limit_hit = tick & bad & (run == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run <= '0;
      else if (clr)            run <= '0;
      else if (tick) begin
         if (!bad || limit_hit) run <= '0;
         else                   run <= run + 1'b1;
      end
   end
endmodule

// File: rtl/lkd_deser_lock.sv
module lkd_deser_lock #(
   parameter int DATA_W     = 10,
   parameter int MISS_LIMIT = 4,
   parameter bit LSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_bit,
   output logic              lock_n,
   output logic [DATA_W-1:0] data_out,
   output logic              data_valid,
   output logic              resend_req
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int CNT_W   = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

   if (DATA_W % 2 != 0 || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be even and at least 2");
   end
   if (MISS_LIMIT < 2) begin : g_bad_limit
      $error("MISS_LIMIT must be at least 2");
   end

   logic              locked;
   logic              lost;
   logic [CNT_W-1:0]  bit_pos;
   logic              sync_hit;
   logic              frame_ok;
   logic [DATA_W-1:0] word;
   logic              frame_end;
   logic              drop;

   assign frame_end = locked && (bit_pos == LAST_BIT);

   lkd_shifter #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(drop), .bit_in(rx_bit),
      .sync_hit(sync_hit), .frame_ok(frame_ok), .word(word)
   );

   lkd_miss_counter #(.LIMIT(MISS_LIMIT)) u_miss (
      .clk(clk), .rst_n(rst_n), .clr(!locked), .tick(frame_end),
      .bad(!frame_ok), .limit_hit(drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked     <= 1'b0;
         lost       <= 1'b0;
         bit_pos    <= '0;
         data_out   <= '0;
         data_valid <= 1'b0;
         resend_req <= 1'b0;
      end else begin
         data_valid <= 1'b0;
         resend_req <= 1'b0;
         if (!locked) begin
            if (sync_hit) begin
               locked     <= 1'b1;
               bit_pos    <= '0;
               resend_req <= lost;
               lost       <= 1'b0;
            end
         end else if (frame_end) begin
            bit_pos <= '0;
            if (drop) begin
               locked <= 1'b0;
               lost   <= 1'b1;
            end else begin
               data_valid <= 1'b1;
               data_out   <= word;
            end
         end else begin
            bit_pos <= bit_pos + 1'b1;
         end
      end
   end

   assign lock_n = !locked;
endmodule

// File: rtl/lkd_deser_lock_chk.sv
module lkd_deser_lock_chk (
   input logic clk,
   input logic rst_n,
   input logic lock_n,
   input logic data_valid,
   input logic resend_req
);
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_idle: assert (lock_n && !data_valid && !resend_req)
            else $error("reset state wrong");
      end
   end

   a_r8_no_word_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      lock_n |-> !data_valid);

   a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |=> !data_valid);

   a_r9_resend_with_relock: assert property (@(posedge clk) disable iff (!rst_n)
      resend_req |-> $fell(lock_n));

   a_r9_resend_single: assert property (@(posedge clk) disable iff (!rst_n)
      resend_req |=> !resend_req);

   a_r7_loss_no_word: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_n) |-> !data_valid);
endmodule

bind lkd_deser_lock lkd_deser_lock_chk u_chk (
   .clk(clk), .rst_n(rst_n), .lock_n(lock_n),
   .data_valid(data_valid), .resend_req(resend_req)
);

// File: tb/sim_lkd_deser_lock.sv
`timescale 1ns/1ps
module sim_lkd_deser_lock;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       rx_bit;
   logic       lock_n;
   logic [9:0] data_out;
   logic       data_valid;
   logic       resend_req;

   int    n_chk  = 0;
   int    n_fail = 0;
   string phase  = "R1";

   // bench model state
   logic [10:0] m_hist   = '0;
   bit          m_locked = 0;
   bit          m_lost   = 0;
   int          m_pos    = 0;
   int          m_miss   = 0;
   logic [9:0]  m_data   = '0;
   bit          e_dv, e_rs;

   always #2 clk = ~clk;

   lkd_deser_lock u0 (.clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .lock_n(lock_n),
      .data_out(data_out), .data_valid(data_valid), .resend_req(resend_req));

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
      end
   endtask

   function automatic logic [9:0] pick_word(input logic [11:0] w);
      logic [9:0] d;
      for (int i = 0; i < 10; i++) d[i] = w[10-i];
      return d;
   endfunction

   // advance model by one bit (R2,R3,R5,R6,R7,R9,R10)
   function automatic void model_bit(input logic b);
      logic [11:0] w;
      w = {m_hist, b};
      e_dv = 0; e_rs = 0;
      m_hist = w[10:0];
      if (!m_locked) begin
         if (w == 12'b111111000000) begin
            m_locked = 1; m_pos = 0; e_rs = m_lost; m_lost = 0;
         end
      end else if (m_pos == 11) begin
         m_pos = 0;
         if (w[11] && !w[0]) m_miss = 0;
         else m_miss++;
         if (m_miss == 4) begin
            m_locked = 0; m_lost = 1; m_miss = 0; m_hist = '0;
         end else begin
            e_dv = 1; m_data = pick_word(w);
         end
      end else m_pos++;
   endfunction

   task automatic send_bit(input logic b);
      rx_bit = b;
      model_bit(b);
      @(posedge clk);
      @(negedge clk);
      chk("lock_n (R2/R7)", lock_n, !m_locked);
      chk("data_valid (R4/R8)", data_valid, e_dv);
      chk("resend_req (R9)", resend_req, e_rs);
      chk("data_out (R4)", data_out, m_data);
   endtask

   task automatic send_frame(input logic s, input logic [9:0] d, input logic e);
      send_bit(s);
      for (int i = 0; i < 10; i++) send_bit(d[i]);
      send_bit(e);
   endtask

   task automatic send_sync();
      send_frame(1'b1, 10'h01F, 1'b0);
   endtask

   task automatic send_bad(input logic [9:0] d);
      logic [1:0] k;
      k = 2'($urandom_range(0, 2));
      if (k == 0)      send_frame(1'b0, d, 1'b0);
      else if (k == 1) send_frame(1'b1, d, 1'b1);
      else             send_frame(1'b0, d, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (R3): actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1021));
      rst_n = 1'b0; rx_bit = 1'b0;
      repeat (2) @(negedge clk);
      phase = "R1";
      chk("lock_n", lock_n, 1); chk("data_valid", data_valid, 0);
      chk("resend_req", resend_req, 0); chk("data_out", data_out, 0);
      rst_n = 1'b1;

      // R8: idle bits with no sync give no words; R2: odd alignment then sync
      phase = "R8";
      for (int i = 0; i < 17; i++) send_bit(1'b0);
      phase = "R2";
      send_bit(1'b1);
      send_sync();
      chk("R2 locked", lock_n, 0);
      chk("R9 no pulse on first lock", resend_req, 0);

      // R3/R4 valid frames
      phase = "R4";
      for (int i = 0; i < 20; i++) send_frame(1'b1, 10'($urandom()), 1'b0);
      send_frame(1'b1, 10'h001, 1'b0);
      chk("R4 first bit in data_out[0]", data_out, 10'h001);

      // R5/R6: three bad, one good, three bad, one good
      phase = "R6";
      for (int r = 0; r < 2; r++) begin
         for (int i = 0; i < 3; i++) send_bad(10'($urandom()));
         chk("R5 lock held after 3 bad", lock_n, 0);
         send_frame(1'b1, 10'($urandom()), 1'b0);
      end
      chk("R6 lock held", lock_n, 0);

      // R7 + R10: fourth bad frame ends with six ones, then six zeros
      phase = "R7";
      for (int i = 0; i < 3; i++) send_bad(10'($urandom()));
      send_frame(1'b0, 10'h3E0, 1'b1);
      chk("R7 lock lost", lock_n, 1);
      phase = "R10";
      for (int i = 0; i < 6; i++) send_bit(1'b0);
      chk("R10 no lock from stale bits", lock_n, 1);

      // R9 relock with resend pulse
      phase = "R9";
      send_bit(1'b0);
      for (int i = 0; i < 11; i++) send_bit(i < 6);
      rx_bit = 1'b0; model_bit(1'b0);
      @(posedge clk); @(negedge clk);
      chk("R9 resend pulse", resend_req, 1);
      chk("R9 lock regained", lock_n, 0);
      send_bit(1'b1);
      chk("R9 pulse single", resend_req, 0);
      for (int i = 0; i < 11; i++) send_bit(1'b0);

      // random mix
      phase = "R3/R5/R7/R9 random";
      for (int n = 0; n < 400; n++) begin
         if (m_locked) begin
            if ($urandom_range(0, 9) < 3) send_bad(10'($urandom()));
            else send_frame(1'b1, 10'($urandom()), 1'b0);
         end else begin
            for (int i = 0; i < int'($urandom_range(0, 3)); i++) send_bit(1'b0);
            if ($urandom_range(0, 1) == 1) send_sync();
            else send_frame(1'($urandom()), 10'($urandom()), 1'($urandom()));
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule